// File: doc/BRIEF.md
# Dual-Rail Threshold-Gate Ripple Adder

This block adds two 4-bit operands and a carry-in. Every operand bit, the carry-in, every sum bit and the carry-out is carried on a pair of rails: a true rail and a false rail. Each carry rail comes from a hysteretic 2-of-3 threshold gate. Each sum rail comes from a hysteretic 3-of-5 threshold gate. The carry ripples from one stage to the next. The block takes alternating wavefronts. First an all-NULL set of inputs, then an all-DATA set. It answers each with the matching wavefront on its outputs. A completion flag shows when every output pair has resolved to DATA, and again when every output pair has returned to NULL.

Each threshold gate is modelled as a pair of flip-flops updated on a sampling clock, so one gate level costs one cycle. A result therefore appears after a number of cycles that depends on the operand values. Short carry chains finish early and long carry chains finish late. An input pair with both rails high is reported on a separate flag and treated as NULL. No output pair ever shows both rails high.

Top module: `ncl_ripple_adder`

## Requirements
- R1: A rail pair (true, false) encodes logic 1 as (1,0), logic 0 as (0,1) and NULL as (0,0). Once all output pairs are DATA, the sum bits and the carry-out equal A + B + carry-in, with sum bit i on pair i and the carry-out as bit W.
- R2: After reset, with NULL inputs, every output rail is low, and the completion and error flags are low.
- R3: Take DATA applied before sampling edge 1. If a stage's two operand bits are equal, its carry-out resolves at edge 1. If they differ, it resolves one edge after its carry-in resolves. The carry-in of stage 0 counts as resolved at edge 0.
- R4: If all three inputs of a sum bit are equal, the sum bit resolves one edge after its carry-in resolves. Otherwise it resolves one edge after the later of its carry-in and its carry-out. Before that edge the sum pair is NULL.
- R5: While every input pair holds legal DATA, no output rail that is high falls.
- R6: After all input pairs return to NULL, every output pair is NULL within W+2 edges.
- R7: The completion flag rises one edge after all sum pairs and the carry-out pair are DATA. It falls one edge after all of them are NULL. In every other case it holds its value.
- R8: The error flag is high, in the same cycle, whenever any input pair has both rails high, and low otherwise. Such a pair is treated as NULL, and no output pair ever has both rails high.
- R9: With W=4, 0+0 with carry-in 0 completes at edge 3. 15+1 with carry-in 0 completes at edge 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the gate state |
| rst_n | input | 1 | Active-low reset; clears every gate to low |
| a_t | input | W | Operand A, true rails |
| a_f | input | W | Operand A, false rails |
| b_t | input | W | Operand B, true rails |
| b_f | input | W | Operand B, false rails |
| cin_t | input | 1 | Carry-in, true rail |
| cin_f | input | 1 | Carry-in, false rail |
| s_t | output | W | Sum, true rails |
| s_f | output | W | Sum, false rails |
| co_t | output | 1 | Carry-out, true rail |
| co_f | output | 1 | Carry-out, false rail |
| done | output | 1 | Hysteretic completion flag |
| err | output | 1 | An input pair has both rails high |

## Verification
The patterns tried are:
- 0+0 with no carry, where every stage kills its carry at once.
- 15+1 and 15+0 with carry-in 1, where a carry travels the full chain.
- Alternating bit patterns that propagate in every stage.
- A sweep of mixed operands in which generate, kill and propagate stages interleave.

Together these separate a result that is right but arrives on the wrong cycle from one that is wrong in value. They also show whether the completion flag tracks the slowest bit or only the first stages. Each DATA wavefront is followed by a NULL wavefront. That second wavefront exposes gates that release too early, too late, or not at all. A final case drives one input pair with both rails high. It checks that the error flag and the stalled chain leave every output pair legal.

// File: rtl/ncl_ripple_adder.sv
module ncl_ripple_adder #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_t,
  input  logic [W-1:0] a_f,
  input  logic [W-1:0] b_t,
  input  logic [W-1:0] b_f,
  input  logic         cin_t,
  input  logic         cin_f,
  output logic [W-1:0] s_t,
  output logic [W-1:0] s_f,
  output logic         co_t,
  output logic         co_f,
  output logic         done,
  output logic         err
);

  function automatic logic [1:0] pair_step(input logic [1:0] q,
                                           input logic t_set, input logic t_clr,
                                           input logic f_set, input logic f_clr);
    logic nf, nt;
    nf = q[0] ? !f_clr : (f_set && !q[1]);
    nt = q[1] ? !t_clr : (t_set && !q[0] && !(f_set && !q[1]));
    return {nt, nf};
  endfunction

  logic [W-1:0] at, af, bt, bf;
  logic [W:0]   ct, cf;
  logic [W-1:0] st_q, sf_q;
  logic         done_q;

  assign at = a_t & ~a_f;
  assign af = a_f & ~a_t;
  assign bt = b_t & ~b_f;
  assign bf = b_f & ~b_t;
  assign ct[0] = cin_t & ~cin_f;
  assign cf[0] = cin_f & ~cin_t;

  assign err = |(a_t & a_f) | |(b_t & b_f) | (cin_t & cin_f);

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic [2:0] cy_t_in, cy_f_in;
    logic [4:0] sm_t_in, sm_f_in;
    logic [1:0] cy_q, sm_q;

    assign cy_t_in = {at[i], bt[i], ct[i]};
    assign cy_f_in = {af[i], bf[i], cf[i]};
    assign sm_t_in = {cy_q[0], cy_q[0], at[i], bt[i], ct[i]};
    assign sm_f_in = {cy_q[1], cy_q[1], af[i], bf[i], cf[i]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cy_q <= 2'b00;
        sm_q <= 2'b00;
      end else begin
        cy_q <= pair_step(cy_q, $countones(cy_t_in) >= 2, cy_t_in == 3'b000,
                                $countones(cy_f_in) >= 2, cy_f_in == 3'b000);
        sm_q <= pair_step(sm_q, $countones(sm_t_in) >= 3, sm_t_in == 5'b00000,
                                $countones(sm_f_in) >= 3, sm_f_in == 5'b00000);
      end
    end

    assign ct[i+1] = cy_q[1];
    assign cf[i+1] = cy_q[0];
    assign st_q[i] = sm_q[1];
    assign sf_q[i] = sm_q[0];
  end

  logic all_data, all_null;
  assign all_data = (&(st_q | sf_q)) & (ct[W] | cf[W]);
  assign all_null = ~(|(st_q | sf_q) | ct[W] | cf[W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (all_data) done_q <= 1'b1;
    else if (all_null) done_q <= 1'b0;
  end

  assign s_t  = st_q;
  assign s_f  = sf_q;
  assign co_t = ct[W];
  assign co_f = cf[W];
  assign done = done_q;

endmodule

// File: rtl/ncl_ripple_adder_props.sv
module ncl_ripple_adder_props #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_t,
  input logic [W-1:0] a_f,
  input logic [W-1:0] b_t,
  input logic [W-1:0] b_f,
  input logic         cin_t,
  input logic         cin_f,
  input logic [W-1:0] s_t,
  input logic [W-1:0] s_f,
  input logic         co_t,
  input logic         co_f,
  input logic         done
);
  logic in_data, out_data, out_null;
  assign in_data  = (&(a_t ^ a_f)) & (&(b_t ^ b_f)) & (cin_t ^ cin_f);
  assign out_data = (&(s_t | s_f)) & (co_t | co_f);
  assign out_null = ~(|(s_t | s_f) | co_t | co_f);

  p_out_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_t & s_f) == '0) && !(co_t && co_f));

  p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_data |=> done);

  p_done_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_null |=> !done);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_data && !out_null) |=> $stable(done));

  p_sum_t_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |=> ((s_t & $past(s_t)) == $past(s_t)));

  p_sum_f_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |=> ((s_f & $past(s_f)) == $past(s_f)));

  p_cout_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && (co_t || co_f)) |=> (co_t == $past(co_t)) && (co_f == $past(co_f)));
endmodule

bind ncl_ripple_adder ncl_ripple_adder_props #(.W(W)) u_props (
  .clk(clk), .rst_n(rst_n), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
  .cin_t(cin_t), .cin_f(cin_f), .s_t(s_t), .s_f(s_f), .co_t(co_t),
  .co_f(co_f), .done(done)
);

// File: tb/sim_ncl_ripple_adder.sv
module sim_ncl_ripple_adder;
  localparam int W = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_t = '0, a_f = '0, b_t = '0, b_f = '0;
  logic cin_t = 1'b0, cin_f = 1'b0;
  logic [W-1:0] s_t, s_f;
  logic co_t, co_f, done, err;
  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  ncl_ripple_adder #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_t(a_t), .a_f(a_f), .b_t(b_t), .b_f(b_f),
    .cin_t(cin_t), .cin_f(cin_f), .s_t(s_t), .s_f(s_f), .co_t(co_t),
    .co_f(co_f), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit outs_data();
    return ((s_t | s_f) == '1) && (co_t || co_f);
  endfunction

  function automatic bit outs_null();
    return (s_t == '0) && (s_f == '0) && !co_t && !co_f;
  endfunction

  task automatic drive_null();
    a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
  endtask

  task automatic run_add(input int a, input int b, input int c);
    int ct[W+1];
    int st[W];
    int tdone, total, maxt;
    bit exp_done, prev_data, prev_null;
    ct[0] = 0;
    for (int i = 0; i < W; i++) begin
      int ai = (a >> i) & 1;
      int bi = (b >> i) & 1;
      int ci = ((a & ((1 << i) - 1)) + (b & ((1 << i) - 1)) + c) >> i;
      ct[i+1] = (ai == bi) ? 1 : ct[i] + 1;
      if (ai == bi && bi == ci) st[i] = ct[i] + 1;
      else st[i] = ((ct[i+1] > ct[i]) ? ct[i+1] : ct[i]) + 1;
    end
    maxt = ct[W];
    for (int i = 0; i < W; i++) if (st[i] > maxt) maxt = st[i];
    tdone = maxt + 1;
    total = a + b + c;

    @(negedge clk);
    a_t = a[W-1:0]; a_f = ~a[W-1:0];
    b_t = b[W-1:0]; b_f = ~b[W-1:0];
    cin_t = c[0]; cin_f = ~c[0];
    for (int n = 1; n <= W + 6; n++) begin
      @(posedge clk);
      @(negedge clk);
      for (int i = 0; i < W; i++) begin
        int e = (n >= st[i]) ? (((total >> i) & 1) ? 2 : 1) : 0;
        chk({s_t[i], s_f[i]} == e[1:0], "R1/R4 sum pair", int'({s_t[i], s_f[i]}), e);
      end
      begin
        int e = (n >= ct[W]) ? (((total >> W) & 1) ? 2 : 1) : 0;
        chk({co_t, co_f} == e[1:0], "R1/R3 carry-out pair", int'({co_t, co_f}), e);
      end
      chk(done == (n >= tdone), "R7 done rise", done, int'(n >= tdone));
      chk(err == 1'b0, "R8 err low on legal input", err, 0);
    end

    @(negedge clk);
    drive_null();
    exp_done = 1'b1;
    prev_data = outs_data();
    prev_null = outs_null();
    for (int n = 1; n <= W + 4; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (prev_data) exp_done = 1'b1;
      else if (prev_null) exp_done = 1'b0;
      chk(done == exp_done, "R7 done during NULL return", done, exp_done);
      chk(((s_t & s_f) == '0) && !(co_t && co_f), "R8 no pair both high", int'(s_t & s_f), 0);
      if (n >= W + 2) chk(outs_null(), "R6 outputs NULL", int'({co_t, co_f, s_t, s_f}), 0);
      prev_data = outs_data();
      prev_null = outs_null();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(outs_null() && !done && !err, "R2 reset state", int'({done, err, s_t, s_f}), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(outs_null() && !done && !err, "R2 after reset release", int'({done, err, s_t, s_f}), 0);

    run_add(0, 0, 0);     // R9 fastest case
    run_add(15, 1, 0);    // R9 longest chain
    run_add(15, 0, 1);
    run_add(5, 10, 0);
    run_add(5, 10, 1);
    run_add(15, 15, 1);
    run_add(7, 9, 0);
    run_add(3, 12, 1);
    for (int k = 0; k < 16; k++) run_add((k * 7 + 3) % 16, (k * 5) % 16, k % 2);

    // R9 explicit completion edges
    begin
      int n;
      @(negedge clk);
      a_t = 4'd0; a_f = 4'hF; b_t = 4'd0; b_f = 4'hF; cin_t = 1'b0; cin_f = 1'b1;
      n = 0;
      while (!done && n < 20) begin @(posedge clk); @(negedge clk); n++; end
      chk(n == 3, "R9 0+0 completion edge", n, 3);
      @(negedge clk); drive_null();
      repeat (W + 4) @(posedge clk);
      @(negedge clk);
      a_t = 4'hF; a_f = 4'h0; b_t = 4'd1; b_f = 4'hE; cin_t = 1'b0; cin_f = 1'b1;
      n = 0;
      while (!done && n < 20) begin @(posedge clk); @(negedge clk); n++; end
      chk(n == 6, "R9 15+1 completion edge", n, 6);
      @(negedge clk); drive_null();
      repeat (W + 4) @(posedge clk);
    end

    // R8 both rails high on operand A bit 0
    @(negedge clk);
    a_t = 4'b0001; a_f = 4'b1111; b_t = 4'b0001; b_f = 4'b1110; cin_t = 1'b1; cin_f = 1'b0;
    #1;
    chk(err == 1'b1, "R8 err raised same cycle", err, 1);
    for (int n = 1; n <= 8; n++) begin
      @(posedge clk);
      @(negedge clk);
      chk(((s_t & s_f) == '0) && !(co_t && co_f), "R8 no pair both high", int'(s_t & s_f), 0);
    end
    chk({s_t[0], s_f[0]} == 2'b00, "R8 illegal pair treated as NULL", int'({s_t[0], s_f[0]}), 0);
    chk(done == 1'b0, "R8 no completion with illegal pair", done, 0);
    drive_null();
    #1;
    chk(err == 1'b0, "R8 err clears", err, 0);
    repeat (W + 4) @(posedge clk);
    @(negedge clk);
    chk(outs_null() && !done, "R6 NULL after illegal case", int'({done, s_t, s_f}), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule